// File: doc/BRIEF.md
# Reference-Gated Frequency Counter Framer

This block measures the frequency of its own clock against a slower, asynchronous reference tick, such as a 1 PPS or 10 kHz timing pulse. It counts every rising edge of the measured clock without pause. Each rising edge of the reference closes one measurement interval. At that point the block captures the count and restarts counting with no edge lost or counted twice.

Each captured count is sent as one fixed-size frame on a byte-wide valid/ready stream, which would normally feed a FIFO toward a host link. A frame is a sync marker of all ones, then a serial number, then the count. Every field goes out most significant byte first. The serial number advances once per reference edge, even when a capture has to be dropped because the previous frame is still being sent. A host can therefore spot missing measurements as a gap in the serial numbers.

Top module: `refcnt_framer`

## Requirements
- R1: While reset is asserted and after it is released, `tx_valid` is low until a reference edge has been seen.
- R2: With default parameters a frame is 8 bytes: bytes 0–1 are the sync marker 0xFF 0xFF, bytes 2–3 are the serial number and bytes 4–7 are the count. Each field is sent most significant byte first.
- R3: The first frame after reset carries serial number 0. Each reference rising edge advances the serial number by exactly one.
- R4: When reference rising edges are N measured-clock cycles apart, every frame except the first one after reset carries the count N.
- R5: Exactly one frame is produced per reference rising edge. A reference level held high for many cycles gives one frame, and no frame appears without an edge.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` hold their values.
- R7: A reference edge that arrives while a frame is still being sent does not start a frame, but it still consumes a serial number. The next frame sent therefore shows a serial-number gap of two.
- R8: When the interval exceeds the counter range, the captured count saturates at all ones instead of wrapping.
- R9: The serial number wraps modulo 2^SEQ_W. After the frame with the all-ones serial number, the next frame carries 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_meas | input | 1 | Measured clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Asynchronous reference tick; its rising edge closes an interval |
| tx_data | output | 8 | Current frame byte |
| tx_valid | output | 1 | Frame byte available |
| tx_ready | input | 1 | Downstream accepts the byte on this clock edge |

## Verification
The assertions assume that `ref_pulse` stays low and stays high for at least as long as the synchronizer depth. This ensures every rising edge is seen as a single edge after synchronization. They also assume `tx_ready` is a plain level sampled on the measured clock. The stimulus drives both signals on the falling edge and holds each reference high for several cycles. Except in the drop scenario, reference edges are spaced far enough apart that a frame can drain with `tx_ready` high. The saturation and serial-wrap cases use a second instance with narrow count and serial fields, so the wrap points can be reached in a short run.

// File: rtl/refcnt_pkg.sv
package refcnt_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic {
      SER_IDLE = 1'b0,
      SER_BUSY = 1'b1
   } ser_state_e;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_pulse
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign rise_pulse = sync_q[STAGES-1] & ~prev_q;

   // R5: an edge marker never lasts two cycles
   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/interval_counter.sv
module interval_counter #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic             cap_stb,
   output logic [CNT_W-1:0] cap_val
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] inc_cnt;

   generate
      if (SATURATE) begin : g_sat
         assign inc_cnt = (run_cnt == CNT_MAX) ? run_cnt : run_cnt + CNT_W'(1);
      end else begin : g_wrap
         assign inc_cnt = run_cnt + CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         cap_val <= '0;
         cap_stb <= 1'b0;
      end else if (tick) begin
         run_cnt <= '0;
         cap_val <= inc_cnt;
         cap_stb <= 1'b1;
      end else begin
         run_cnt <= inc_cnt;
         cap_stb <= 1'b0;
      end
   end

   // R4: the running count restarts right after each interval end
   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (run_cnt == '0) && cap_stb);

   generate
      if (SATURATE) begin : g_sat_chk
         // R8: a full counter stays full until the next interval end
         p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (run_cnt == CNT_MAX) && !tick |=> run_cnt == CNT_MAX);
      end
   endgenerate
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
   parameter int CNT_W  = 32,
   parameter int SEQ_W  = 16,
   parameter int FLAG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_stb,
   input  logic [CNT_W-1:0] cap_val,
   output logic [7:0]       tx_data,
   output logic             tx_valid,
   input  logic             tx_ready
);
   import refcnt_pkg::*;

   localparam int FRAME_W     = FLAG_W + SEQ_W + CNT_W;
   localparam int FRAME_BYTES = FRAME_W / BYTE_W;
   localparam int IDX_W       = $clog2(FRAME_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

   ser_state_e         state_q;
   logic [SEQ_W-1:0]   seq_q;
   logic [FRAME_W-1:0] frame_q;
   logic [IDX_W-1:0]   idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SER_IDLE;
         seq_q   <= '0;
         frame_q <= '0;
         idx_q   <= '0;
      end else begin
         if (cap_stb) seq_q <= seq_q + SEQ_W'(1);
         case (state_q)
            SER_IDLE: begin
               if (cap_stb) begin
                  frame_q <= {{FLAG_W{1'b1}}, seq_q, cap_val};
                  idx_q   <= '0;
                  state_q <= SER_BUSY;
               end
            end
            default: begin
               if (tx_ready) begin
                  frame_q <= frame_q << BYTE_W;
                  if (idx_q == LAST_IDX) state_q <= SER_IDLE;
                  else                   idx_q   <= idx_q + IDX_W'(1);
               end
            end
         endcase
      end
   end

   assign tx_data  = frame_q[FRAME_W-1 -: BYTE_W];
   assign tx_valid = (state_q == SER_BUSY);

   // R6: a stalled byte holds
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
   // R3: every capture consumes one serial number
   p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> seq_q == $past(seq_q) + SEQ_W'(1));
   // R2: a frame opens with the marker byte
   p_flag_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> tx_data == 8'hFF);
   // R2: the frame ends after its last byte
   p_frame_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && (idx_q == LAST_IDX) |=> !tx_valid);
   // R7: a capture during a stalled frame does not disturb it
   p_drop_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb && tx_valid && !tx_ready |=> idx_q == $past(idx_q) && $stable(frame_q));
endmodule

// File: rtl/refcnt_framer.sv
module refcnt_framer #(
   parameter int CNT_W       = 32,
   parameter int SEQ_W       = 16,
   parameter int FLAG_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic       clk_meas,
   input  logic       rst_n,
   input  logic       ref_pulse,
   output logic [7:0] tx_data,
   output logic       tx_valid,
   input  logic       tx_ready
);
   generate
      if (CNT_W % 8 != 0 || CNT_W < 8) begin : g_bad_cnt
         $error("CNT_W must be a positive multiple of 8");
      end
      if (SEQ_W % 8 != 0 || SEQ_W < 8) begin : g_bad_seq
         $error("SEQ_W must be a positive multiple of 8");
      end
      if (FLAG_W % 8 != 0 || FLAG_W < 8) begin : g_bad_flag
         $error("FLAG_W must be a positive multiple of 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             ref_rise;
   logic             cap_stb;
   logic [CNT_W-1:0] cap_val;

   ref_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk_meas),
      .rst_n     (rst_n),
      .async_in  (ref_pulse),
      .rise_pulse(ref_rise)
   );

   interval_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_count (
      .clk    (clk_meas),
      .rst_n  (rst_n),
      .tick   (ref_rise),
      .cap_stb(cap_stb),
      .cap_val(cap_val)
   );

   frame_serializer #(.CNT_W(CNT_W), .SEQ_W(SEQ_W), .FLAG_W(FLAG_W)) u_ser (
      .clk     (clk_meas),
      .rst_n   (rst_n),
      .cap_stb (cap_stb),
      .cap_val (cap_val),
      .tx_data (tx_data),
      .tx_valid(tx_valid),
      .tx_ready(tx_ready)
   );

   // R1: nothing is offered in the cycle after reset release
   p_idle_after_reset_r1: assert property (@(posedge clk_meas) disable iff (!rst_n)
      $rose(rst_n) |-> !tx_valid);
endmodule

// File: tb/refcnt_framer_tb.sv
module refcnt_framer_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_a = 1'b0;
   logic ref_b = 1'b0;
   logic rdy_a = 1'b1;
   logic [7:0] dat_a, dat_b;
   logic vld_a, vld_b;

   int checks = 0;
   int fails  = 0;
   logic [7:0] bytes_a[$];
   logic [7:0] bytes_b[$];

   always #2.5 clk = ~clk;

   refcnt_framer u_dut (
      .clk_meas(clk), .rst_n(rst_n), .ref_pulse(ref_a),
      .tx_data(dat_a), .tx_valid(vld_a), .tx_ready(rdy_a)
   );

   refcnt_framer #(.CNT_W(8), .SEQ_W(8)) u_dut_sat (
      .clk_meas(clk), .rst_n(rst_n), .ref_pulse(ref_b),
      .tx_data(dat_b), .tx_valid(vld_b), .tx_ready(1'b1)
   );

   // capture handshakes just before each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #4;
         if (rst_n && vld_a && rdy_a) bytes_a.push_back(dat_a);
         if (rst_n && vld_b) bytes_b.push_back(dat_b);
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int frames_a();
      return bytes_a.size() / 8;
   endfunction
   function automatic logic [15:0] flag_a(int f);
      return {bytes_a[8*f], bytes_a[8*f+1]};
   endfunction
   function automatic logic [15:0] seq_a(int f);
      return {bytes_a[8*f+2], bytes_a[8*f+3]};
   endfunction
   function automatic logic [31:0] cnt_a(int f);
      return {bytes_a[8*f+4], bytes_a[8*f+5], bytes_a[8*f+6], bytes_a[8*f+7]};
   endfunction

   // one reference period of gap cycles, high for hi cycles
   task automatic pulse_a(input int gap, input int hi);
      @(negedge clk);
      ref_a = 1'b1;
      repeat (hi) @(negedge clk);
      ref_a = 1'b0;
      repeat (gap - hi - 1) @(negedge clk);
   endtask
   task automatic pulse_b(input int gap);
      @(negedge clk);
      ref_b = 1'b1;
      repeat (3) @(negedge clk);
      ref_b = 1'b0;
      repeat (gap - 4) @(negedge clk);
   endtask
   task automatic settle();
      repeat (40) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!vld_a && !vld_b, "R1 valid during reset", vld_a, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(!vld_a && !vld_b, "R1 valid after reset", vld_a, 0);
      chk(bytes_a.size() == 0, "R1 no bytes before edge", bytes_a.size(), 0);
   endtask

   task automatic t_steady();
      int base = frames_a();
      for (int i = 0; i < 4; i++) pulse_a(40, 3);
      settle();
      chk(frames_a() == base + 4, "R5 one frame per edge", frames_a(), base + 4);
      chk(bytes_a.size() % 8 == 0, "R2 frame length", bytes_a.size() % 8, 0);
      chk(flag_a(base) == 16'hFFFF, "R2 sync marker", flag_a(base), 16'hFFFF);
      chk(seq_a(base) == 16'd0, "R3 first serial", seq_a(base), 0);
      for (int f = 1; f < 4; f++) begin
         chk(seq_a(base + f) == 16'(f), "R3 serial step", seq_a(base + f), f);
         chk(cnt_a(base + f) == 32'd40, "R4 count gap 40", cnt_a(base + f), 40);
         chk(flag_a(base + f) == 16'hFFFF, "R2 sync marker", flag_a(base + f), 16'hFFFF);
      end
   endtask

   task automatic t_other_gap();
      int base = frames_a();
      pulse_a(57, 5);
      pulse_a(57, 5);
      settle();
      chk(frames_a() == base + 2, "R5 frames gap 57", frames_a(), base + 2);
      chk(cnt_a(base + 1) == 32'd57, "R4 count gap 57", cnt_a(base + 1), 57);
      chk(seq_a(base + 1) == seq_a(base) + 16'd1, "R3 serial step", seq_a(base + 1), seq_a(base) + 1);
   endtask

   task automatic t_long_high();
      int base = frames_a();
      pulse_a(80, 60);
      settle();
      chk(frames_a() == base + 1, "R5 long high one frame", frames_a(), base + 1);
      repeat (100) @(negedge clk);
      chk(frames_a() == base + 1 && !vld_a, "R5 no frame without edge", frames_a(), base + 1);
   endtask

   task automatic t_stall();
      int base = frames_a();
      logic [7:0] held;
      rdy_a = 1'b0;
      pulse_a(12, 3);
      chk(vld_a, "R6 frame pending", vld_a, 1);
      chk(dat_a == 8'hFF, "R2 first byte marker", dat_a, 8'hFF);
      held = dat_a;
      repeat (10) @(negedge clk);
      chk(vld_a && dat_a == held, "R6 byte held", dat_a, held);
      chk(bytes_a.size() == 8 * base, "R6 nothing taken", bytes_a.size(), 8 * base);
      rdy_a = 1'b1;
      settle();
      chk(frames_a() == base + 1, "R6 frame after release", frames_a(), base + 1);
   endtask

   task automatic t_drop();
      int base = frames_a();
      logic [15:0] s0;
      rdy_a = 1'b0;
      pulse_a(20, 3);
      pulse_a(20, 3);
      rdy_a = 1'b1;
      settle();
      chk(frames_a() == base + 1, "R7 busy edge dropped", frames_a(), base + 1);
      s0 = seq_a(base);
      pulse_a(30, 3);
      settle();
      chk(frames_a() == base + 2, "R7 next frame sent", frames_a(), base + 2);
      chk(seq_a(base + 1) == s0 + 16'd2, "R7 serial gap", seq_a(base + 1), s0 + 2);
   endtask

   task automatic t_saturate();
      pulse_b(100);
      pulse_b(300);
      pulse_b(50);
      settle();
      chk(bytes_b.size() == 12, "R8 sat frames", bytes_b.size(), 12);
      chk(bytes_b[7] == 8'd100, "R8 in-range count", bytes_b[7], 100);
      chk(bytes_b[11] == 8'hFF, "R8 saturated count", bytes_b[11], 8'hFF);
   endtask

   task automatic t_wrap();
      int n;
      while (bytes_b.size() / 4 < 258) pulse_b(16);
      settle();
      n = bytes_b.size() / 4;
      chk(n == 258, "R9 frame total", n, 258);
      chk(bytes_b[4*255+2] == 8'hFF, "R9 last serial", bytes_b[4*255+2], 8'hFF);
      chk(bytes_b[4*256+2] == 8'h00, "R9 serial wraps", bytes_b[4*256+2], 0);
      chk(bytes_b[4*257+2] == 8'h01, "R9 after wrap", bytes_b[4*257+2], 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      t_steady();
      t_other_gap();
      t_long_high();
      t_stall();
      t_drop();
      t_saturate();
      t_wrap();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule